// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. A lookup presents a virtual address. In the same cycle the block answers with a hit flag, a miss flag, the physical address and the protection bits of the matching entry. Each entry is tagged with an address-space identifier, so the cache holds translations for several processes at once. Only entries whose tag equals the current identifier, or whose global bit is set, can match. A context switch only reloads the current identifier and leaves every entry in place.

A miss is left to an external page-table walker. The walker resolves the translation and installs it through the fill port, and the retried access then hits. Normal 4 KiB pages and 2 MiB huge pages share the same array; a per-entry size bit selects how many address bits are compared. Two commands remove translations: one clears the whole array, and one clears the non-global entries of a single identifier.

The lookup port has no back-pressure: it is always accepted and answers combinationally. The fill port is valid/ready. A fill is taken at a rising edge where both `fill_valid` and `fill_ready` are high. `fill_ready` is low in any cycle that carries an invalidate command. The walker must hold its fill stable until it is accepted.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and `fill_ready` is high while no invalidate command is present.
- R2: A lookup with `lk_valid` high that hits a 4 KiB entry returns, in the same cycle, `lk_hit`=1, `lk_miss`=0, the entry's protection bits, and `lk_pa` = {frame number, `lk_va[11:0]`}. `lk_hit` and `lk_miss` are both 0 while `lk_valid` is low.
- R3: A lookup with no matching entry gives `lk_miss`=1, `lk_hit`=0, `lk_pa`=0 and `lk_prot`=0. A fill accepted at an edge makes the retried lookup hit in the next cycle.
- R4: An entry with its global bit set matches under any current identifier. A non-global entry matches only when its stored identifier equals the current one, which `asid_set` loads from `asid_new` at the next edge.
- R5: Changing the current identifier invalidates no entry. Switching back to an earlier identifier makes its translations hit again.
- R6: A 2 MiB entry compares only `lk_va[31:21]` against the upper 11 bits of its stored page number, and returns `lk_pa` = {upper 11 frame bits, `lk_va[20:0]`}.
- R7: A fill that conflicts with no entry is written into the lowest-indexed invalid entry.
- R8: When all entries are valid and there is no conflict, the fill replaces the entry selected by a round-robin pointer. The pointer starts at 0 after reset, advances by one (wrapping after the last entry) only on such replacing fills, and keeps its value on every other fill.
- R9: An existing valid entry conflicts with a fill when their identifiers overlap (equal, or either one global) and their page numbers agree at the coarser of the two page sizes. The lowest conflicting entry is overwritten, the other conflicting entries are invalidated, and no lookup ever matches more than one entry.
- R10: An invalidate-by-identifier command clears every non-global entry whose identifier equals `inv_id`, and keeps global entries and entries of other identifiers.
- R11: An invalidate-all command clears every entry, global ones included, at the next edge.
- R12: In a cycle with `inv_all` or `inv_id_en` high, `fill_ready` is low and a presented fill is not installed. The invalidation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_miss | output | 1 | Lookup found no matching entry |
| lk_pa | output | 32 | Translated physical address (0 on miss) |
| lk_prot | output | 3 | Protection bits of the matching entry (0 on miss) |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_vpn | input | 20 | Virtual page number of the new translation |
| fill_pfn | input | 20 | Physical frame number of the new translation |
| fill_prot | input | 3 | Protection bits of the new translation |
| fill_global | input | 1 | New translation matches under any identifier |
| fill_large | input | 1 | New translation is a 2 MiB page |
| fill_asid | input | 8 | Identifier the new translation belongs to |
| asid_set | input | 1 | Load a new current identifier |
| asid_new | input | 8 | Value of the new current identifier |
| inv_all | input | 1 | Invalidate every entry |
| inv_id_en | input | 1 | Invalidate non-global entries of one identifier |
| inv_id | input | 8 | Identifier to invalidate |

## Verification
A corrupt valid bit, tag or size bit shows up at the ports in the very next lookup of the affected page. The lookup is combinational, so the fault appears as a wrong hit/miss flag or a wrong physical address in the same cycle the address is presented. A replacement pointer that drifts only becomes visible one fill later, when an unexpected page disappears. For that reason every page ever installed is probed again after each fill, switch and invalidation. A broken conflict rule leaves two entries matching one address, which corrupts the OR-combined physical address at once.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int OFF_BITS      = 12;
  localparam int HUGE_OFF_BITS = 21;

  typedef enum logic [1:0] {
    SRC_MERGE = 2'd0,
    SRC_FREE  = 2'd1,
    SRC_EVICT = 2'd2
  } fill_src_e;
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot #(
  parameter int VPNW  = 20,
  parameter int PFNW  = 20,
  parameter int ASIDW = 8,
  parameter int PROTW = 3,
  parameter int LBITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inv_id_en,
  input  logic [ASIDW-1:0] inv_id,
  input  logic             wr,
  input  logic             kill,
  input  logic [VPNW-1:0]  f_vpn,
  input  logic [PFNW-1:0]  f_pfn,
  input  logic [PROTW-1:0] f_prot,
  input  logic             f_glob,
  input  logic             f_large,
  input  logic [ASIDW-1:0] f_asid,
  input  logic [VPNW-1:0]  lk_vpn,
  input  logic [ASIDW-1:0] cur_asid,
  output logic             hit,
  output logic             conflict,
  output logic [PFNW-1:0]  frame,
  output logic [PROTW-1:0] prot,
  output logic             valid,
  output logic             glob,
  output logic [ASIDW-1:0] asid
);
  logic             large_q;
  logic [VPNW-1:0]  vpn_q;
  logic [PFNW-1:0]  pfn_q;
  logic [PROTW-1:0] prot_q;
  logic             tag_ok, page_ok, f_tag_ok, f_page_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                                     valid <= 1'b0;
    else if (clr)                                   valid <= 1'b0;
    else if (inv_id_en && !glob && asid == inv_id)  valid <= 1'b0;
    else if (wr)                                    valid <= 1'b1;
    else if (kill)                                  valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      glob    <= f_glob;
      large_q <= f_large;
      asid    <= f_asid;
      vpn_q   <= f_vpn;
      pfn_q   <= f_pfn;
      prot_q  <= f_prot;
    end
  end

  always_comb begin
    tag_ok  = glob || (asid == cur_asid);
    page_ok = large_q ? (vpn_q[VPNW-1:LBITS] == lk_vpn[VPNW-1:LBITS])
                      : (vpn_q == lk_vpn);
    hit     = valid && tag_ok && page_ok;
    frame   = '0;
    prot    = '0;
    if (hit) begin
      frame = large_q ? {pfn_q[PFNW-1:LBITS], lk_vpn[LBITS-1:0]} : pfn_q;
      prot  = prot_q;
    end
    f_tag_ok  = glob || f_glob || (asid == f_asid);
    f_page_ok = (large_q || f_large) ? (vpn_q[VPNW-1:LBITS] == f_vpn[VPNW-1:LBITS])
                                     : (vpn_q == f_vpn);
    conflict  = valid && f_tag_ok && f_page_ok;
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int NENT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [NENT-1:0] valid,
  input  logic [NENT-1:0] conflict,
  output logic [NENT-1:0] wr,
  output logic [NENT-1:0] kill
);
  import tlb_pkg::*;
  localparam int IDXW = (NENT > 1) ? $clog2(NENT) : 1;

  logic [IDXW-1:0] rr_q;
  logic [NENT-1:0] target;
  fill_src_e       src;

  function automatic logic [NENT-1:0] lowest(input logic [NENT-1:0] v);
    logic [NENT-1:0] r;
    r = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    if (|conflict)    src = SRC_MERGE;
    else if (&valid)  src = SRC_EVICT;
    else              src = SRC_FREE;
    case (src)
      SRC_MERGE: target = lowest(conflict);
      SRC_FREE:  target = lowest(~valid);
      default:   target = NENT'(1) << rr_q;
    endcase
    wr   = fire ? target : '0;
    kill = (fire && src == SRC_MERGE) ? (conflict & ~target) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rr_q <= '0;
    else if (fire && src == SRC_EVICT)
      rr_q <= (rr_q == IDXW'(NENT - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int NENT  = 16,
  parameter int VAW   = 32,
  parameter int PAW   = 32,
  parameter int ASIDW = 8,
  parameter int PROTW = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             lk_valid,
  input  logic [VAW-1:0]                   lk_va,
  output logic                             lk_hit,
  output logic                             lk_miss,
  output logic [PAW-1:0]                   lk_pa,
  output logic [PROTW-1:0]                 lk_prot,
  input  logic                             fill_valid,
  output logic                             fill_ready,
  input  logic [VAW-tlb_pkg::OFF_BITS-1:0] fill_vpn,
  input  logic [PAW-tlb_pkg::OFF_BITS-1:0] fill_pfn,
  input  logic [PROTW-1:0]                 fill_prot,
  input  logic                             fill_global,
  input  logic                             fill_large,
  input  logic [ASIDW-1:0]                 fill_asid,
  input  logic                             asid_set,
  input  logic [ASIDW-1:0]                 asid_new,
  input  logic                             inv_all,
  input  logic                             inv_id_en,
  input  logic [ASIDW-1:0]                 inv_id
);
  localparam int OFFW  = tlb_pkg::OFF_BITS;
  localparam int LBITS = tlb_pkg::HUGE_OFF_BITS - tlb_pkg::OFF_BITS;
  localparam int VPNW  = VAW - OFFW;
  localparam int PFNW  = PAW - OFFW;

  logic [ASIDW-1:0]            cur_asid;
  logic [NENT-1:0]             hit_vec, conf_vec, valid_vec, glob_vec, wr_vec, kill_vec;
  logic [NENT-1:0][PFNW-1:0]   frame_v;
  logic [NENT-1:0][PROTW-1:0]  prot_v;
  logic [NENT-1:0][ASIDW-1:0]  asid_arr;
  logic [PFNW-1:0]             frame_or;
  logic [PROTW-1:0]            prot_or;
  logic                        fire, any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)        cur_asid <= '0;
    else if (asid_set) cur_asid <= asid_new;
  end

  assign fill_ready = !(inv_all || inv_id_en);
  assign fire       = fill_valid && fill_ready;

  tlb_pick #(.NENT(NENT)) u_pick (
    .clk(clk), .rst_n(rst_n), .fire(fire), .valid(valid_vec),
    .conflict(conf_vec), .wr(wr_vec), .kill(kill_vec)
  );

  for (genvar g = 0; g < NENT; g++) begin : g_slot
    tlb_slot #(.VPNW(VPNW), .PFNW(PFNW), .ASIDW(ASIDW), .PROTW(PROTW), .LBITS(LBITS)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(inv_all), .inv_id_en(inv_id_en), .inv_id(inv_id),
      .wr(wr_vec[g]), .kill(kill_vec[g]),
      .f_vpn(fill_vpn), .f_pfn(fill_pfn), .f_prot(fill_prot),
      .f_glob(fill_global), .f_large(fill_large), .f_asid(fill_asid),
      .lk_vpn(lk_va[VAW-1:OFFW]), .cur_asid(cur_asid),
      .hit(hit_vec[g]), .conflict(conf_vec[g]), .frame(frame_v[g]), .prot(prot_v[g]),
      .valid(valid_vec[g]), .glob(glob_vec[g]), .asid(asid_arr[g])
    );
  end

  always_comb begin
    frame_or = '0;
    prot_or  = '0;
    for (int i = 0; i < NENT; i++) begin
      frame_or = frame_or | frame_v[i];
      prot_or  = prot_or | prot_v[i];
    end
  end

  assign any_hit = |hit_vec;
  assign lk_hit  = lk_valid && any_hit;
  assign lk_miss = lk_valid && !any_hit;
  assign lk_pa   = lk_hit ? {frame_or, lk_va[OFFW-1:0]} : '0;
  assign lk_prot = lk_hit ? prot_or : '0;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int NENT  = 16,
  parameter int ASIDW = 8,
  parameter int PAW   = 32,
  parameter int PROTW = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            lk_valid,
  input logic                            lk_hit,
  input logic                            lk_miss,
  input logic [PAW-1:0]                  lk_pa,
  input logic [PROTW-1:0]                lk_prot,
  input logic                            fill_valid,
  input logic                            fill_ready,
  input logic                            asid_set,
  input logic                            inv_all,
  input logic                            inv_id_en,
  input logic [ASIDW-1:0]                inv_id,
  input logic [NENT-1:0]                 hit_vec,
  input logic [NENT-1:0]                 valid_vec,
  input logic [NENT-1:0]                 glob_vec,
  input logic [NENT-1:0][ASIDW-1:0]      asid_arr
);
  logic             inv_pend;
  logic [ASIDW-1:0] inv_seen;
  logic             stale;

  always_ff @(posedge clk) begin
    if (!rst_n) inv_pend <= 1'b0;
    else        inv_pend <= inv_id_en && !inv_all;
    inv_seen <= inv_id;
  end

  always_comb begin
    stale = 1'b0;
    for (int i = 0; i < NENT; i++)
      if (valid_vec[i] && !glob_vec[i] && asid_arr[i] == inv_seen) stale = 1'b1;
  end

  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
  p_flush_all_r11:   assert property (@(posedge clk) disable iff (!rst_n) inv_all |=> valid_vec == '0);
  p_switch_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
                       (asid_set && !inv_all && !inv_id_en && !fill_valid) |=> $stable(valid_vec));
  p_inv_by_id_r10:   assert property (@(posedge clk) disable iff (!rst_n) inv_pend |-> !stale);
  p_fill_block_r12:  assert property (@(posedge clk) disable iff (!rst_n) (inv_all || inv_id_en) |-> !fill_ready);
  p_fill_lands_r3:   assert property (@(posedge clk) disable iff (!rst_n) (fill_valid && fill_ready) |=> |valid_vec);
  p_miss_quiet_r3:   assert property (@(posedge clk) disable iff (!rst_n)
                       lk_miss |-> (lk_pa == '0 && lk_prot == '0 && !lk_hit));
  p_hit_gated_r2:    assert property (@(posedge clk) disable iff (!rst_n) (lk_hit || lk_miss) |-> lk_valid);
endmodule

bind asid_tlb tlb_chk #(.NENT(NENT), .ASIDW(ASIDW), .PAW(PAW), .PROTW(PROTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_pa(lk_pa), .lk_prot(lk_prot), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .asid_set(asid_set), .inv_all(inv_all), .inv_id_en(inv_id_en), .inv_id(inv_id),
  .hit_vec(hit_vec), .valid_vec(valid_vec), .glob_vec(glob_vec), .asid_arr(asid_arr)
);

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic lk_hit, lk_miss, fill_ready;
  logic [31:0] lk_pa;
  logic [2:0] lk_prot;
  logic fill_valid = 1'b0, fill_global = 1'b0, fill_large = 1'b0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [2:0] fill_prot = '0;
  logic [7:0] fill_asid = '0, asid_new = '0, inv_id = '0;
  logic asid_set = 1'b0, inv_all = 1'b0, inv_id_en = 1'b0;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  bit         m_v[N], m_g[N], m_l[N];
  logic [7:0] m_asid[N];
  logic [19:0] m_vpn[N], m_pfn[N];
  logic [2:0] m_prot[N];
  int         m_rr = 0;
  logic [7:0] m_cur = '0;
  logic [19:0] pv[64];
  int         pn = 0;

  asid_tlb u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic add_probe(input logic [19:0] v);
    if (pn < 64) begin pv[pn] = v; pn++; end
  endtask

  task automatic model_fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] prot,
                            input bit g, input bit l, input logic [7:0] asid);
    int tgt;
    tgt = -1;
    for (int k = 0; k < N; k++) begin
      if (m_v[k] && (m_g[k] || g || m_asid[k] == asid) &&
          ((m_l[k] || l) ? (m_vpn[k][19:9] == vpn[19:9]) : (m_vpn[k] == vpn))) begin
        if (tgt < 0) tgt = k;
        else m_v[k] = 0;
      end
    end
    if (tgt < 0)
      for (int k = N - 1; k >= 0; k--) if (!m_v[k]) tgt = k;
    if (tgt < 0) begin
      tgt  = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_v[tgt] = 1; m_g[tgt] = g; m_l[tgt] = l; m_asid[tgt] = asid;
    m_vpn[tgt] = vpn; m_pfn[tgt] = pfn; m_prot[tgt] = prot;
  endtask

  task automatic probe(input string phase, input logic [31:0] va);
    bit eh; logic [31:0] epa; logic [2:0] epr; string kind;
    eh = 0; epa = '0; epr = '0; kind = "R3";
    for (int k = 0; k < N; k++) begin
      if (m_v[k] && (m_g[k] || m_asid[k] == m_cur) &&
          (m_l[k] ? (m_vpn[k][19:9] == va[31:21]) : (m_vpn[k] == va[31:12]))) begin
        eh  = 1;
        epr = m_prot[k];
        epa = m_l[k] ? {m_pfn[k][19:9], va[20:0]} : {m_pfn[k], va[11:0]};
        kind = m_l[k] ? "R6" : ((m_g[k] && m_asid[k] != m_cur) ? "R4" : "R2");
      end
    end
    @(negedge clk);
    lk_valid = 1'b1;
    lk_va    = va;
    #1;
    check({phase, "/", kind}, {26'b0, lk_hit, lk_miss, lk_pa, lk_prot},
          {26'b0, eh, !eh, epa, epr});
  endtask

  task automatic sweep(input string phase);
    for (int i = 0; i < pn; i++) begin
      probe(phase, {pv[i], 12'((i * 13 + 5) & 12'hfff)});
      probe(phase, {pv[i][19:9], 21'((i * 40503 + 777) & 21'h1fffff)});
    end
    @(negedge clk);
    lk_valid = 1'b0;
    #1;
    check({phase, "/R2 idle"}, {62'b0, lk_hit, lk_miss}, 64'd0);
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] prot,
                         input bit g, input bit l, input logic [7:0] asid);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_prot = prot;
    fill_global = g; fill_large = l; fill_asid = asid;
    #1 check("R12 ready", {63'b0, fill_ready}, 64'd1);
    @(negedge clk);
    fill_valid = 1'b0;
    model_fill(vpn, pfn, prot, g, l, asid);
    add_probe(vpn);
  endtask

  task automatic set_asid(input logic [7:0] a);
    @(negedge clk);
    asid_set = 1'b1; asid_new = a;
    @(negedge clk);
    asid_set = 1'b0;
    m_cur = a;
  endtask

  task automatic inv_by(input logic [7:0] id, input bit with_fill);
    @(negedge clk);
    inv_id_en = 1'b1; inv_id = id;
    fill_valid = with_fill; fill_vpn = 20'hBEEF0; fill_pfn = 20'h11111;
    fill_global = 1'b1; fill_large = 1'b0; fill_asid = id;
    #1 check("R12 blocked", {63'b0, fill_ready}, 64'd0);
    @(negedge clk);
    inv_id_en = 1'b0; fill_valid = 1'b0;
    for (int k = 0; k < N; k++) if (!m_g[k] && m_asid[k] == id) m_v[k] = 0;
  endtask

  task automatic flush(input bit with_fill);
    @(negedge clk);
    inv_all = 1'b1;
    fill_valid = with_fill; fill_vpn = 20'hBEEF1; fill_pfn = 20'h22222;
    fill_global = 1'b1; fill_large = 1'b0; fill_asid = m_cur;
    #1 check("R12 blocked", {63'b0, fill_ready}, 64'd0);
    @(negedge clk);
    inv_all = 1'b0; fill_valid = 1'b0;
    for (int k = 0; k < N; k++) m_v[k] = 0;
  endtask

  initial begin
    for (int k = 0; k < N; k++) m_v[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 ready", {63'b0, fill_ready}, 64'd1);
    add_probe(20'h00001); add_probe(20'h12345); add_probe(20'h40400);
    sweep("R1");

    set_asid(8'd5);
    for (int i = 0; i < 6; i++)
      do_fill(20'h00100 + 20'(i), 20'h80000 + 20'(i * 7), 3'(i), i == 2, 1'b0, 8'd5);
    sweep("R7");

    do_fill(20'h40200, 20'hA5600, 3'd5, 1'b0, 1'b1, 8'd5);
    add_probe(20'h40211); add_probe(20'h403FF);
    sweep("R6");

    do_fill(20'h40233, 20'h12345, 3'd6, 1'b0, 1'b0, 8'd5);
    do_fill(20'h00102, 20'h0C0DE, 3'd7, 1'b0, 1'b0, 8'd9);
    sweep("R9");

    set_asid(8'd9);
    sweep("R4");
    for (int i = 0; i < 14; i++)
      do_fill(20'h00100 + 20'(i), 20'h90000 + 20'(i * 3), 3'(i + 1), 1'b0, 1'b0, 8'd9);
    sweep("R8");
    do_fill(20'h7F000, 20'h7F001, 3'd4, 1'b1, 1'b0, 8'd33);
    do_fill(20'h50000, 20'h50505, 3'd2, 1'b0, 1'b1, 8'd9);
    sweep("R8");

    set_asid(8'd5);
    sweep("R5");
    set_asid(8'd9);
    sweep("R5");

    inv_by(8'd5, 1'b1);
    sweep("R10");
    set_asid(8'd5);
    sweep("R10");

    flush(1'b1);
    sweep("R11");

    do_fill(20'h00AAA, 20'h0BBBB, 3'd3, 1'b0, 1'b0, 8'd5);
    sweep("R3");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule